// File: doc/BRIEF.md
# Banked Memory Mapping Unit

This block sits between a processor with a 16-bit address bus and a 2 MB physical memory. The logical space is cut into eight fixed windows of 8 KB. The top three address bits pick a window. Each window has its own 8-bit page register, and that register names one of 256 physical 8 KB pages. The page number is joined to the 13-bit in-window offset to form a 21-bit physical address. The translation is purely combinational.

The processor changes the page registers only through accumulator transfers. A write copies the accumulator into every register named in a select mask. A read returns one register to the accumulator. No other path touches the registers. There are no restrictions on the mapping, so windows may share a page, sit on adjacent pages or point anywhere. After reset the top window maps page 0x00, so the vectors at the top of the logical space resolve to physical page zero.

The control is a set of parallel registers with a priority pick. No state machine is needed.

Top module: `bank_mapper`

## Requirements
- R1: Physical address bits 12..0 always equal logical address bits 12..0.
- R2: Physical address bits 20..13 equal the page register chosen by logical address bits 15..13 (window 0 at the bottom of the space, window 7 at the top), with no clock delay.
- R3: After reset, window 7 holds page 0x00, window i (i = 0..6) holds page i, and acc_out is 0x00.
- R4: On a clock edge with wr_en high, every register whose sel_mask bit is set (bit i selects window i) takes acc_in. Registers whose bit is clear keep their value.
- R5: Any number of windows may hold the same page, and each of them then translates to that page.
- R6: On a clock edge with rd_en high and a nonzero mask, acc_out takes the register of the lowest-numbered set mask bit.
- R7: A transfer with an all-zero mask changes no register, and acc_out keeps the last transferred value.
- R8: A write with a nonzero mask and rd_en low makes acc_out equal to the written value after the edge.
- R9: When wr_en and rd_en are both high with a nonzero mask, the registers take acc_in and acc_out takes the pre-write content of the lowest selected register.
- R10: While wr_en is low, no page register changes, whatever sel_mask and acc_in carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| log_addr | input | 16 | Logical address from the processor |
| phys_addr | output | 21 | Translated physical address |
| wr_en | input | 1 | Accumulator-to-register transfer strobe |
| rd_en | input | 1 | Register-to-accumulator transfer strobe |
| sel_mask | input | 8 | One bit per window; selects the transfer targets |
| acc_in | input | 8 | Accumulator value to be written |
| acc_out | output | 8 | Last transferred value, returned to the accumulator |

## Verification
The hardest case to reach from the ports is a read whose mask has several bits set. The answer depends on the priority order, which is only visible when every register holds a different value. The bench first loads eight distinct pages one window at a time, then reads with every one of the 255 nonzero masks, so that each lowest-bit position is hit under every pattern of higher bits. Aliasing and the combined read-and-write case are reached by multi-bit writes and checked by sweeping all eight windows afterwards.

// File: rtl/bank_mapper_pkg.sv
package bank_mapper_pkg;

    // Reset page for a window: the top window maps page zero, the others map their own index.
    function automatic int unsigned reset_page(input int unsigned idx, input int unsigned nwin);
        return (idx == nwin - 1) ? 0 : idx;
    endfunction

endpackage

// File: rtl/bank_map_regs.sv
module bank_map_regs #(
    parameter int unsigned NUM_WIN = 8,
    parameter int unsigned PAGE_W  = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [NUM_WIN-1:0]          sel_mask,
    input  logic [PAGE_W-1:0]           wr_data,
    output logic [NUM_WIN*PAGE_W-1:0]   map_flat
);
    import bank_mapper_pkg::*;

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        localparam logic [PAGE_W-1:0] RST_VAL = PAGE_W'(reset_page(g, NUM_WIN));
        logic [PAGE_W-1:0] page_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                page_q <= RST_VAL;
            end else if (wr_en && sel_mask[g]) begin
                page_q <= wr_data;
            end
        end

        assign map_flat[g*PAGE_W +: PAGE_W] = page_q;
    end

endmodule

// File: rtl/bank_map_xlate.sv
module bank_map_xlate #(
    parameter int unsigned LOG_W    = 16,
    parameter int unsigned WIN_BITS = 3,
    parameter int unsigned PAGE_W   = 8,
    localparam int unsigned NUM_WIN = 1 << WIN_BITS,
    localparam int unsigned OFF_W   = LOG_W - WIN_BITS
) (
    input  logic [NUM_WIN*PAGE_W-1:0]  map_flat,
    input  logic [LOG_W-1:0]           log_addr,
    output logic [PAGE_W+OFF_W-1:0]    phys_addr
);
    logic [WIN_BITS-1:0] win_sel;
    logic [PAGE_W-1:0]   page;

    assign win_sel   = log_addr[LOG_W-1 -: WIN_BITS];
    assign page      = map_flat[win_sel*PAGE_W +: PAGE_W];
    assign phys_addr = {page, log_addr[OFF_W-1:0]};

endmodule

// File: rtl/bank_map_readback.sv
module bank_map_readback #(
    parameter int unsigned NUM_WIN = 8,
    parameter int unsigned PAGE_W  = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic                        rd_en,
    input  logic [NUM_WIN-1:0]          sel_mask,
    input  logic [PAGE_W-1:0]           wr_data,
    input  logic [NUM_WIN*PAGE_W-1:0]   map_flat,
    output logic [PAGE_W-1:0]           acc_out
);
    localparam int unsigned IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;

    logic [IDX_W-1:0]  pick;
    logic              any_sel;
    logic [PAGE_W-1:0] picked;
    logic [PAGE_W-1:0] last_q;

    // Lowest set mask bit wins: scan from the top so the lowest index is written last.
    always_comb begin
        pick = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (sel_mask[i]) begin
                pick = IDX_W'(i);
            end
        end
    end

    assign any_sel = |sel_mask;
    assign picked  = map_flat[pick*PAGE_W +: PAGE_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_q <= '0;
        end else if (rd_en && any_sel) begin
            last_q <= picked;
        end else if (wr_en && any_sel) begin
            last_q <= wr_data;
        end
    end

    assign acc_out = last_q;

endmodule

// File: rtl/bank_mapper.sv
module bank_mapper #(
    parameter int unsigned LOG_W    = 16,
    parameter int unsigned WIN_BITS = 3,
    parameter int unsigned PAGE_W   = 8
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic [LOG_W-1:0]                        log_addr,
    output logic [PAGE_W+LOG_W-WIN_BITS-1:0]        phys_addr,
    input  logic                                    wr_en,
    input  logic                                    rd_en,
    input  logic [(1<<WIN_BITS)-1:0]                sel_mask,
    input  logic [PAGE_W-1:0]                       acc_in,
    output logic [PAGE_W-1:0]                       acc_out
);
    localparam int unsigned NUM_WIN = 1 << WIN_BITS;

    logic [NUM_WIN*PAGE_W-1:0] map_flat;

    bank_map_regs #(
        .NUM_WIN (NUM_WIN),
        .PAGE_W  (PAGE_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .sel_mask (sel_mask),
        .wr_data  (acc_in),
        .map_flat (map_flat)
    );

    bank_map_xlate #(
        .LOG_W    (LOG_W),
        .WIN_BITS (WIN_BITS),
        .PAGE_W   (PAGE_W)
    ) u_xlate (
        .map_flat  (map_flat),
        .log_addr  (log_addr),
        .phys_addr (phys_addr)
    );

    bank_map_readback #(
        .NUM_WIN (NUM_WIN),
        .PAGE_W  (PAGE_W)
    ) u_rdbk (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .sel_mask (sel_mask),
        .wr_data  (acc_in),
        .map_flat (map_flat),
        .acc_out  (acc_out)
    );

endmodule

// File: rtl/bank_mapper_chk.sv
module bank_mapper_chk #(
    parameter int unsigned LOG_W    = 16,
    parameter int unsigned WIN_BITS = 3,
    parameter int unsigned PAGE_W   = 8
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic [LOG_W-1:0]                  log_addr,
    input logic [PAGE_W+LOG_W-WIN_BITS-1:0]  phys_addr,
    input logic                              wr_en,
    input logic                              rd_en,
    input logic [(1<<WIN_BITS)-1:0]          sel_mask,
    input logic [PAGE_W-1:0]                 acc_in,
    input logic [PAGE_W-1:0]                 acc_out
);
    localparam int unsigned OFF_W = LOG_W - WIN_BITS;

    // R1: offset bits pass through untouched
    p_offset_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
        phys_addr[OFF_W-1:0] == log_addr[OFF_W-1:0]);

    // R4: a write that targets the current window shows up in translation next cycle
    p_write_visible_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel_mask[log_addr[LOG_W-1 -: WIN_BITS]])
        |=> (log_addr != $past(log_addr)) || (phys_addr[PAGE_W+OFF_W-1:OFF_W] == $past(acc_in)));

    // R8: a write-only transfer returns the written value
    p_write_echo_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_en && (sel_mask != '0)) |=> acc_out == $past(acc_in));

    // R7: no effective transfer leaves acc_out alone
    p_acc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_mask == '0 || (!wr_en && !rd_en)) |=> $stable(acc_out));

    // R10: without a write, a steady address keeps a steady translation
    p_map_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (log_addr != $past(log_addr)) || $stable(phys_addr));

endmodule

bind bank_mapper bank_mapper_chk #(
    .LOG_W    (LOG_W),
    .WIN_BITS (WIN_BITS),
    .PAGE_W   (PAGE_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .log_addr  (log_addr),
    .phys_addr (phys_addr),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .sel_mask  (sel_mask),
    .acc_in    (acc_in),
    .acc_out   (acc_out)
);

// File: tb/bank_mapper_tb.sv
module bank_mapper_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] log_addr = '0;
    logic [20:0] phys_addr;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  sel_mask = '0;
    logic [7:0]  acc_in = '0;
    logic [7:0]  acc_out;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    logic [7:0] mdl [8];
    logic [7:0] exp_acc;

    always #5 clk = ~clk;

    bank_mapper u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .log_addr  (log_addr),
        .phys_addr (phys_addr),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .sel_mask  (sel_mask),
        .acc_in    (acc_in),
        .acc_out   (acc_out)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    function automatic int lowest(input logic [7:0] m);
        for (int i = 7; i >= 0; i--) begin
            if (m[i]) lowest = i;
        end
    endfunction

    task automatic xfer(input logic w, input logic r, input logic [7:0] m, input logic [7:0] a);
        @(negedge clk);
        wr_en = w; rd_en = r; sel_mask = m; acc_in = a;
        @(posedge clk);
        #2;
        wr_en = 1'b0; rd_en = 1'b0; sel_mask = '0; acc_in = 8'hEE;
    endtask

    task automatic sweep(input string req);
        logic [12:0] offs [3];
        offs[0] = 13'h0000; offs[1] = 13'h1FFF; offs[2] = 13'h0A5A;
        for (int w = 0; w < 8; w++) begin
            for (int k = 0; k < 3; k++) begin
                log_addr = {w[2:0], offs[k]};
                #1;
                chk(req, 32'(phys_addr), 32'({mdl[w], offs[k]}));
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog got=hung exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 7; i++) mdl[i] = 8'(i);
        mdl[7] = 8'h00;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;

        // R3 reset defaults, R1/R2 translation
        chk("R3 acc reset", 32'(acc_out), 32'h0);
        sweep("R3/R1/R2 reset map");

        // R10: wr_en low, full mask, data present
        xfer(1'b0, 1'b0, 8'hFF, 8'h77);
        sweep("R10 no write");
        chk("R10 acc", 32'(acc_out), 32'h0);

        // R4/R8: single-window writes with distinct pages
        for (int i = 0; i < 8; i++) begin
            xfer(1'b1, 1'b0, 8'(1 << i), 8'(8'hA1 + i * 8'h13));
            mdl[i] = 8'(8'hA1 + i * 8'h13);
            chk("R8 write echo", 32'(acc_out), 32'(mdl[i]));
        end
        sweep("R4/R2 single writes");

        // R6: every nonzero read mask
        for (int m = 1; m < 256; m++) begin
            xfer(1'b0, 1'b1, 8'(m), 8'h00);
            chk("R6 read priority", 32'(acc_out), 32'(mdl[lowest(8'(m))]));
        end

        // R7: zero-mask read and write
        xfer(1'b0, 1'b1, 8'h80, 8'h00);
        exp_acc = mdl[7];
        xfer(1'b0, 1'b1, 8'h00, 8'h00);
        chk("R7 zero read", 32'(acc_out), 32'(exp_acc));
        xfer(1'b1, 1'b0, 8'h00, 8'h3C);
        chk("R7 zero write acc", 32'(acc_out), 32'(exp_acc));
        sweep("R7 zero write map");

        // R4/R5: multi-window write creating aliases
        xfer(1'b1, 1'b0, 8'b1010_0101, 8'h5C);
        for (int i = 0; i < 8; i++) if (i == 0 || i == 2 || i == 5 || i == 7) mdl[i] = 8'h5C;
        sweep("R5 alias");
        chk("R8 multi echo", 32'(acc_out), 32'h5C);

        // R9: simultaneous read and write
        exp_acc = mdl[1];
        xfer(1'b1, 1'b1, 8'b0100_0010, 8'hC3);
        mdl[1] = 8'hC3; mdl[6] = 8'hC3;
        chk("R9 read old value", 32'(acc_out), 32'(exp_acc));
        sweep("R9 regs written");

        // R4: full-mask write, then back to adjacent pages
        xfer(1'b1, 1'b0, 8'hFF, 8'hFF);
        for (int i = 0; i < 8; i++) mdl[i] = 8'hFF;
        sweep("R4 full mask");
        for (int i = 0; i < 8; i++) begin
            xfer(1'b1, 1'b0, 8'(1 << i), 8'(8'h40 + i));
            mdl[i] = 8'(8'h40 + i);
        end
        sweep("R2 contiguous");

        // R3 again after a second reset
        @(negedge clk); rst_n = 1'b0;
        #3;
        for (int i = 0; i < 7; i++) mdl[i] = 8'(i);
        mdl[7] = 8'h00;
        chk("R3 acc re-reset", 32'(acc_out), 32'h0);
        sweep("R3 re-reset map");
        @(negedge clk); rst_n = 1'b1;

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule